// File: doc/BRIEF.md
# Register-Target Branch and Link Unit

This unit resolves the two branch instructions of a 32-bit load-store processor. Each cycle it takes the instruction word, the address of that instruction, and the values already read from the target register (rb) and the tested register (rc). One clock later it presents the next fetch address, a flag that tells whether control is redirected, and a write request that carries the return address to a destination register.

A branch always jumps to the address held in a register. There is no branch to an immediate or PC-relative address, so software loads the target into a register first. Three low bits of the constant field choose among never, always, zero, nonzero, non-negative and negative tests on the rc value. The linking opcode writes the return address whatever the outcome of the test. With the never condition, the linking form therefore only captures the return address. The return address is the address of the next instruction.

The registered outputs change only on the clock. The asynchronous active-low reset is released in step with the clock.

Top module: `bru_unit`

## Requirements
- R1: Instruction fields are opcode at bits 31..27, destination index ra at 26..22 and condition at 2..0. Opcode 8 is a plain branch and opcode 9 is a linking branch. When the condition holds, `next_pc_o` equals `rb_val_i` and `taken_o` is 1 on the cycle after the inputs are sampled.
- R2: Condition 000 never holds and 001 always holds. Condition 010 holds when `rc_val_i` is zero and 011 holds when it is nonzero. The bits from 11 to 3 of the instruction do not change the outcome.
- R3: Condition 100 holds when bit 31 of `rc_val_i` is 0, and condition 101 holds when that bit is 1. No other bit of the value matters.
- R4: Conditions 110 and 111 never hold.
- R5: When the branch is not taken, `next_pc_o` equals `pc_i + 4`, taken modulo 2^32, and `taken_o` is 0.
- R6: For opcode 9, `link_we_o` is 1, `link_idx_o` equals ra and `link_val_o` equals `pc_i + 4`. This holds whether or not the branch is taken, and it also holds for condition 000.
- R7: For opcode 8, and for any opcode other than 8 or 9, `link_we_o` is 0 and the link index and value are 0. An opcode other than 8 or 9 also keeps `taken_o` at 0 and gives `next_pc_o = pc_i + 4`.
- R8: When ra equals the rb field, the jump still goes to the `rb_val_i` presented with the instruction. The link value is still `pc_i + 4`.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rb_val_i | input | 32 | Value of the target register |
| rc_val_i | input | 32 | Value of the tested register |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Branch redirects control |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link destination register index |
| link_val_o | output | 32 | Return address to be written |

## Verification
The tested value is swept across zero, small positive values, the largest positive value, the most negative value and all-ones. These points separate the zero tests from the sign tests and show that only bit 31 decides the sign. Each condition code is driven with both plain and linking opcodes. This exposes a link that wrongly depends on the outcome and a never-linking case that drops its write. Reserved codes, foreign opcodes, noise in the upper constant bits, a link index equal to the target index, and a wrapping PC near the top of the address space each test one decode or arithmetic corner.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    CND_NEVER   = 3'b000,
    CND_ALWAYS  = 3'b001,
    CND_ZERO    = 3'b010,
    CND_NONZERO = 3'b011,
    CND_NONNEG  = 3'b100,
    CND_NEG     = 3'b101,
    CND_RSV6    = 3'b110,
    CND_RSV7    = 3'b111
  } cond_e;

  localparam int unsigned COND_W = 3;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int unsigned ILEN   = 32,
  parameter int unsigned OP_W   = 5,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned OP_BR  = 8,
  parameter int unsigned OP_BRL = 9
) (
  input  logic [ILEN-1:0]   instr,
  output logic              is_br,
  output logic              is_link,
  output logic [RIDX_W-1:0] ra_idx,
  output cond_e             cond
);
  localparam int unsigned OP_LSB = ILEN - OP_W;
  localparam int unsigned RA_LSB = OP_LSB - RIDX_W;

  logic [OP_W-1:0] opcode;
  logic            unused_fields;

  assign opcode        = instr[ILEN-1:OP_LSB];
  assign ra_idx        = instr[RA_LSB +: RIDX_W];
  assign cond          = cond_e'(instr[COND_W-1:0]);
  assign unused_fields = ^instr[RA_LSB-1:COND_W];

  always_comb begin
    is_br   = 1'b0;
    is_link = 1'b0;
    if (opcode == OP_W'(OP_BR)) begin
      is_br = 1'b1;
    end else if (opcode == OP_W'(OP_BRL)) begin
      is_br   = 1'b1;
      is_link = 1'b1;
    end
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cond_e           cond,
  input  logic [XLEN-1:0] test_val,
  output logic            met
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (test_val == '0);
  assign is_neg  = test_val[XLEN-1];

  always_comb begin
    unique case (cond)
      CND_ALWAYS:  met = 1'b1;
      CND_ZERO:    met = is_zero;
      CND_NONZERO: met = !is_zero;
      CND_NONNEG:  met = !is_neg;
      CND_NEG:     met = is_neg;
      default:     met = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_link.sv
module bru_link #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              is_link,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]   seq_pc,
  output logic              we,
  output logic [RIDX_W-1:0] idx,
  output logic [XLEN-1:0]   val
);
  always_comb begin
    we  = is_link;
    idx = is_link ? ra_idx : '0;
    val = is_link ? seq_pc : '0;
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned OP_W   = 5,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned OP_BR  = 8,
  parameter int unsigned OP_BRL = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [XLEN-1:0]   rc_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(XLEN / 8);

  logic [1:0] rst_sync_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  logic              dec_br;
  logic              dec_link;
  logic [RIDX_W-1:0] dec_ra;
  cond_e             dec_cond;
  logic              cond_met;
  logic [XLEN-1:0]   seq_pc;
  logic              lk_we;
  logic [RIDX_W-1:0] lk_idx;
  logic [XLEN-1:0]   lk_val;

  bru_decode #(
    .ILEN(XLEN), .OP_W(OP_W), .RIDX_W(RIDX_W), .OP_BR(OP_BR), .OP_BRL(OP_BRL)
  ) u_decode (
    .instr(instr_i), .is_br(dec_br), .is_link(dec_link),
    .ra_idx(dec_ra), .cond(dec_cond)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .cond(dec_cond), .test_val(rc_val_i), .met(cond_met)
  );

  assign seq_pc = pc_i + PC_STEP;

  bru_link #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_link (
    .is_link(dec_link), .ra_idx(dec_ra), .seq_pc(seq_pc),
    .we(lk_we), .idx(lk_idx), .val(lk_val)
  );

  logic [XLEN-1:0]   next_pc_d;
  logic              taken_d;
  logic              out_en;

  always_comb begin
    taken_d   = dec_br && cond_met;
    next_pc_d = taken_d ? rb_val_i : seq_pc;
    out_en    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
    end else if (out_en) begin
      next_pc_o  <= next_pc_d;
      taken_o    <= taken_d;
      link_we_o  <= lk_we;
      link_idx_o <= lk_idx;
      link_val_o <= lk_val;
    end
  end
endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned OP_W   = 5,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned OP_BR  = 8,
  parameter int unsigned OP_BRL = 9
) (
  input logic              clk,
  input logic              rst_n_q,
  input logic [XLEN-1:0]   instr_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   rb_val_i,
  input logic              taken_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              link_we_o,
  input logic [RIDX_W-1:0] link_idx_o,
  input logic [XLEN-1:0]   link_val_o
);
  localparam int unsigned OP_LSB = XLEN - OP_W;
  localparam int unsigned RA_LSB = OP_LSB - RIDX_W;

  logic primed;
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) primed <= 1'b0;
    else          primed <= 1'b1;
  end

  logic [OP_W-1:0] op_w;
  logic            br_w;
  assign op_w = instr_i[XLEN-1:OP_LSB];
  assign br_w = (op_w == OP_W'(OP_BR)) || (op_w == OP_W'(OP_BRL));

  a_r1_taken_target: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && taken_o |-> next_pc_o == $past(rb_val_i));

  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(XLEN / 8));

  a_r4_reserved_never: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && $past(br_w && instr_i[2:1] == 2'b11) |-> !taken_o);

  a_r6_link_always: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && $past(op_w == OP_W'(OP_BRL)) |->
      link_we_o && link_val_o == $past(pc_i) + XLEN'(XLEN / 8)
      && link_idx_o == $past(instr_i[RA_LSB +: RIDX_W]));

  a_r7_no_link: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && $past(op_w != OP_W'(OP_BRL)) |-> !link_we_o);

  a_r7_foreign_op: assert property (@(posedge clk) disable iff (!rst_n_q)
    primed && $past(!br_w) |-> !taken_o);
endmodule

bind bru_unit bru_unit_chk #(
  .XLEN(XLEN), .OP_W(OP_W), .RIDX_W(RIDX_W), .OP_BR(OP_BR), .OP_BRL(OP_BRL)
) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .instr_i(instr_i), .pc_i(pc_i),
  .rb_val_i(rb_val_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
  .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o)
);

// File: tb/tb_bru_unit.sv
module tb_bru_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr_i, pc_i, rb_val_i, rc_val_i;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  bru_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .pc_i(pc_i),
    .rb_val_i(rb_val_i), .rc_val_i(rc_val_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
    .link_val_o(link_val_o)
  );

  typedef struct {
    string       tag;
    logic [31:0] npc;
    logic        tkn;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] val;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mk(input int op, input int ra, input int rb,
                                     input int rc, input logic [11:0] k);
    return {op[4:0], ra[4:0], rb[4:0], rc[4:0], k};
  endfunction

  task automatic send(input string tag, input logic [31:0] ins, input logic [31:0] pc,
                      input logic [31:0] rbv, input logic [31:0] rcv);
    exp_t e;
    logic [4:0] op;
    logic [2:0] c;
    logic hold;
    @(negedge clk);
    instr_i = ins; pc_i = pc; rb_val_i = rbv; rc_val_i = rcv;
    op = ins[31:27];
    c  = ins[2:0];
    case (c)
      3'b001:  hold = 1'b1;
      3'b010:  hold = (rcv == 32'd0);
      3'b011:  hold = (rcv != 32'd0);
      3'b100:  hold = !rcv[31];
      3'b101:  hold = rcv[31];
      default: hold = 1'b0;
    endcase
    e.tag = tag;
    e.tkn = (op == 5'd8 || op == 5'd9) && hold;
    e.npc = e.tkn ? rbv : pc + 32'd4;
    e.we  = (op == 5'd9);
    e.idx = e.we ? ins[26:22] : 5'd0;
    e.val = e.we ? pc + 32'd4 : 32'd0;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (next_pc_o !== e.npc || taken_o !== e.tkn || link_we_o !== e.we ||
            link_idx_o !== e.idx || link_val_o !== e.val) begin
          fails++;
          $display("FAIL %s: got npc=%h tkn=%b we=%b idx=%0d val=%h exp npc=%h tkn=%b we=%b idx=%0d val=%h",
                   e.tag, next_pc_o, taken_o, link_we_o, link_idx_o, link_val_o,
                   e.npc, e.tkn, e.we, e.idx, e.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_i = mk(8, 0, 0, 0, 12'h001); pc_i = 32'h100; rb_val_i = 32'h5000; rc_val_i = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (next_pc_o !== 0 || taken_o !== 0 || link_we_o !== 0 || link_idx_o !== 0 || link_val_o !== 0) begin
      fails++;
      $display("FAIL R9: got npc=%h tkn=%b we=%b exp all zero", next_pc_o, taken_o, link_we_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send("R1 always",            mk(8, 3, 4, 5, 12'h001), 32'h0000_1000, 32'h0000_2000, 32'd7);
    send("R2 never",             mk(8, 3, 4, 5, 12'h000), 32'h0000_1004, 32'h0000_2000, 32'd0);
    send("R2 zero hit",          mk(8, 0, 4, 5, 12'h002), 32'h0000_1008, 32'h0000_3000, 32'd0);
    send("R2 zero miss",         mk(8, 0, 4, 5, 12'h002), 32'h0000_100C, 32'h0000_3000, 32'd1);
    send("R2 nonzero hit",       mk(8, 0, 4, 5, 12'h003), 32'h0000_1010, 32'h0000_3100, 32'd5);
    send("R2 nonzero miss",      mk(8, 0, 4, 5, 12'h003), 32'h0000_1014, 32'h0000_3100, 32'd0);
    send("R2 upper const noise", mk(8, 0, 4, 5, 12'hFFA), 32'h0000_1018, 32'h0000_3200, 32'd0);
    send("R3 nonneg zero",       mk(8, 0, 4, 5, 12'h004), 32'h0000_2000, 32'h0000_4000, 32'd0);
    send("R3 nonneg maxpos",     mk(8, 0, 4, 5, 12'h004), 32'h0000_2004, 32'h0000_4004, 32'h7FFF_FFFF);
    send("R3 nonneg minneg",     mk(8, 0, 4, 5, 12'h004), 32'h0000_2008, 32'h0000_4008, 32'h8000_0000);
    send("R3 neg minneg",        mk(8, 0, 4, 5, 12'h005), 32'h0000_200C, 32'h0000_400C, 32'h8000_0000);
    send("R3 neg allones",       mk(8, 0, 4, 5, 12'h005), 32'h0000_2010, 32'h0000_4010, 32'hFFFF_FFFF);
    send("R3 neg positive",      mk(8, 0, 4, 5, 12'h005), 32'h0000_2014, 32'h0000_4014, 32'd1);
    send("R4 code6",             mk(8, 0, 4, 5, 12'h006), 32'h0000_2018, 32'h0000_4018, 32'd0);
    send("R4 code7",             mk(9, 2, 4, 5, 12'h007), 32'h0000_201C, 32'h0000_401C, 32'hFFFF_FFFF);
    send("R6 link never",        mk(9, 6, 0, 0, 12'h000), 32'h0000_3000, 32'h0000_9000, 32'd0);
    send("R6 link zero miss",    mk(9, 7, 5, 1, 12'h002), 32'h0000_3004, 32'h0000_9004, 32'd3);
    send("R6 link neg hit",      mk(9, 31, 3, 1, 12'h005), 32'h0000_3008, 32'h0000_9008, 32'h8000_0001);
    send("R8 ra equals rb",      mk(9, 4, 4, 0, 12'h001), 32'h0000_300C, 32'h0000_A000, 32'd0);
    send("R7 foreign op",        mk(3, 5, 4, 5, 12'h001), 32'h0000_3010, 32'h0000_B000, 32'd0);
    send("R7 foreign op0",       mk(0, 9, 4, 5, 12'h001), 32'h0000_3014, 32'h0000_B000, 32'd0);
    send("R5 pc wrap",           mk(8, 0, 4, 5, 12'h000), 32'hFFFF_FFFC, 32'h0000_C000, 32'd0);
    send("R6 link pc wrap",      mk(9, 1, 4, 5, 12'h000), 32'hFFFF_FFFC, 32'h0000_C000, 32'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule